// File: doc/BRIEF.md
# Serial Control Register Decoder for a Stereo Volume and Tone Processor

This block is the digital front end of a low-voltage stereo volume and tone processor. It listens on a two-wire serial bus as a write-only target, samples both bus lines with the system clock, and finds START and STOP conditions on the synchronized lines. It acknowledges its fixed device address and each byte that follows. The first byte after the address selects one of three control registers and can enable automatic advance of the index. Each later byte in the transfer is written to the selected register.

The register contents are decoded straight onto control outputs for the analog path. These outputs are the total volume attenuation in dB, output gain and output damping, the two mute flags, standby, treble and bass boost level, and the bass level-control settings. Read transfers and clock stretching are not supported. The serial clock must run at no more than one eighth of the system clock rate.

Top module: `audio_ctl_i2c`

## Requirements
- R1: The block acknowledges (drives `sda_pull_o` high during the ninth clock) only the address byte 0x88, which is device address 0x44 with the write bit 0. Any other address byte gets no acknowledge, and no byte of that transfer gets an acknowledge or changes a register.
- R2: After a matching address, every following byte (index byte and data bytes) is acknowledged, and `sda_pull_o` changes only while the synchronized serial clock is low.
- R3: The first byte after the address is the index byte. Bits 3..0 pick the register (0 = general control, 1 = bass control, 2 = volume), and bits 7..5 are ignored.
- R4: When index-byte bit 4 is 1, each data byte advances the index by one after the write. From an index of 2 or higher, the next index is 0. When bit 4 is 0, all data bytes go to the same register.
- R5: Data bytes aimed at an index above 2 are acknowledged and discarded, and no register changes.
- R6: A STOP or a repeated START ends the transfer. The first byte after the next matching address is again taken as an index byte.
- R7: On the synchronous reset, all registers and decoded outputs are zero and `sda_pull_o` is low.
- R8: Volume register: bits 2..0 give 1 dB steps and bits 5..3 give 8 dB steps, so `vol_atten_o` = 8*bits[5:3] + bits[2:0] (0 to 63). Bit 6 drives `out_gain_o` (+14 dB) and bit 7 drives `out_damp_o` (-10 dB).
- R9: General control register: bit 0 = standby, bit 1 = input mute, bit 2 = output mute, bit 3 = treble high boost (+8 dB when 1, +4 dB when 0).
- R10: Bass control register: bit 0 = bass high boost (+14 dB when 1, +6 dB when 0), bits 2..1 = level-control speed step (each step halves the release current), bits 4..3 = threshold step (0.2, 0.14, 0.1, 0.07 Vrms), bit 5 = level control enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_pull_o | output | 1 | Pull the data line low (acknowledge) |
| standby_o | output | 1 | Stop all circuits |
| in_mute_o | output | 1 | Input mute |
| out_mute_o | output | 1 | Output mute |
| treble_hi_o | output | 1 | Treble high boost select |
| bass_hi_o | output | 1 | Bass high boost select |
| alc_en_o | output | 1 | Bass level control enable |
| alc_speed_o | output | 2 | Level-control speed step |
| alc_thresh_o | output | 2 | Level-control threshold step |
| vol_atten_o | output | 6 | Total volume attenuation in dB |
| out_gain_o | output | 1 | Output gain +14 dB |
| out_damp_o | output | 1 | Output damping -10 dB |

## Verification
The assertions assume a well-formed bus. The data line changes only while the serial clock is low, except at START and STOP. Each clock level lasts several system clocks, so the synchronized edges of the two lines never fall in the same cycle. The bench drives the bus with a bit-level model at a fixed quarter-period of four system clocks and changes the data line only in the low phase. It randomizes address bytes, index values (including unused indexes and the ignored top bits), the auto-advance bit and transfer length, and it mixes in repeated START cases.

// File: rtl/actl_pkg.sv
package actl_pkg;
   localparam int BYTE_W = 8;
   // general control register fields
   localparam int GC_STANDBY = 0;
   localparam int GC_IN_MUTE = 1;
   localparam int GC_OUT_MUTE = 2;
   localparam int GC_TREBLE_HI = 3;
   // bass control register fields
   localparam int BC_BASS_HI = 0;
   localparam int BC_SPEED_LSB = 1;
   localparam int BC_THRESH_LSB = 3;
   localparam int BC_ALC_EN = 5;
   // volume register fields
   localparam int VR_FINE_LSB = 0;
   localparam int VR_COARSE_LSB = 3;
   localparam int VR_GAIN = 6;
   localparam int VR_DAMP = 7;
   // register indexes
   localparam int IDX_GEN = 0;
   localparam int IDX_BASS = 1;
   localparam int IDX_VOL = 2;

   typedef enum logic [1:0] {
      RX_IDLE = 2'd0,
      RX_ADDR = 2'd1,
      RX_DATA = 2'd2,
      RX_ACK  = 2'd3
   } rx_state_t;
endpackage

// File: rtl/actl_sync.sv
module actl_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   generate
      if (STAGES < 2) begin : g_bad
         $error("actl_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) stage[s] <= '1;
            else if (s == 0) stage[s] <= d;
            else stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/actl_bus_rx.sv
module actl_bus_rx
   import actl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h44
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_s,
   input  logic              sda_s,
   output logic              sda_pull,
   output logic              start_det,
   output logic              byte_stb,
   output logic              byte_first,
   output logic [BYTE_W-1:0] byte_data
);
   localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
   localparam logic [3:0] BITS = 4'(BYTE_W);

   logic scl_q, sda_q, stop_det, scl_rise, scl_fall;
   rx_state_t state;
   logic [3:0] cnt;
   logic [BYTE_W-1:0] shreg;
   logic first_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= RX_IDLE;
         cnt        <= '0;
         shreg      <= '0;
         first_q    <= 1'b0;
         sda_pull   <= 1'b0;
         byte_stb   <= 1'b0;
         byte_first <= 1'b0;
         byte_data  <= '0;
      end else begin
         byte_stb <= 1'b0;
         if (start_det) begin
            state    <= RX_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_det) begin
            state    <= RX_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (state)
               RX_ADDR, RX_DATA: begin
                  if (scl_rise && cnt < BITS) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == BITS) begin
                     if (state == RX_ADDR) begin
                        if (shreg == ADDR_WR) begin
                           sda_pull <= 1'b1;
                           first_q  <= 1'b1;
                           state    <= RX_ACK;
                        end else begin
                           state <= RX_IDLE;
                        end
                     end else begin
                        sda_pull   <= 1'b1;
                        state      <= RX_ACK;
                        byte_stb   <= 1'b1;
                        byte_data  <= shreg;
                        byte_first <= first_q;
                        first_q    <= 1'b0;
                     end
                  end
               end
               RX_ACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     cnt      <= '0;
                     state    <= RX_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/actl_regs.sv
module actl_regs
   import actl_pkg::*;
#(
   parameter int NUM_REGS = 3,
   parameter int IDX_W = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       byte_stb,
   input  logic                       byte_first,
   input  logic [BYTE_W-1:0]          byte_data,
   output logic [NUM_REGS*BYTE_W-1:0] reg_flat,
   output logic [IDX_W-1:0]           wr_idx
);
   localparam int INC_BIT = IDX_W;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

   logic inc_en;
   logic data_wr;

   assign data_wr = byte_stb & ~byte_first;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_idx <= '0;
         inc_en <= 1'b0;
      end else if (byte_stb && byte_first) begin
         wr_idx <= byte_data[IDX_W-1:0];
         inc_en <= byte_data[INC_BIT];
      end else if (data_wr && inc_en) begin
         wr_idx <= (wr_idx >= LAST) ? '0 : wr_idx + 1'b1;
      end
   end

   generate
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         logic [BYTE_W-1:0] value;
         always_ff @(posedge clk) begin
            if (rst) value <= '0;
            else if (data_wr && wr_idx == IDX_W'(r)) value <= byte_data;
         end
         assign reg_flat[r*BYTE_W +: BYTE_W] = value;
      end
   endgenerate
endmodule

// File: rtl/audio_ctl_i2c.sv
module audio_ctl_i2c
   import actl_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h44,
   parameter int NUM_REGS = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   output logic       standby_o,
   output logic       in_mute_o,
   output logic       out_mute_o,
   output logic       treble_hi_o,
   output logic       bass_hi_o,
   output logic       alc_en_o,
   output logic [1:0] alc_speed_o,
   output logic [1:0] alc_thresh_o,
   output logic [5:0] vol_atten_o,
   output logic       out_gain_o,
   output logic       out_damp_o
);
   localparam int IDX_W = 4;

   generate
      if (NUM_REGS < 3 || NUM_REGS > (1 << IDX_W)) begin : g_bad_regs
         $error("NUM_REGS must lie between 3 and 16");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s, sda_s;
   logic start_det, byte_stb, byte_first;
   logic [BYTE_W-1:0] byte_data;
   logic [NUM_REGS*BYTE_W-1:0] reg_flat;
   logic [IDX_W-1:0] wr_idx;
   logic [BYTE_W-1:0] gen_r, bass_r, vol_r;
   logic [2:0] fine, coarse;

   actl_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({scl_i, sda_i}),
      .q   ({scl_s, sda_s})
   );

   actl_bus_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
      .clk        (clk),
      .rst        (rst),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .sda_pull   (sda_pull_o),
      .start_det  (start_det),
      .byte_stb   (byte_stb),
      .byte_first (byte_first),
      .byte_data  (byte_data)
   );

   actl_regs #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .byte_stb   (byte_stb),
      .byte_first (byte_first),
      .byte_data  (byte_data),
      .reg_flat   (reg_flat),
      .wr_idx     (wr_idx)
   );

   assign gen_r  = reg_flat[IDX_GEN*BYTE_W +: BYTE_W];
   assign bass_r = reg_flat[IDX_BASS*BYTE_W +: BYTE_W];
   assign vol_r  = reg_flat[IDX_VOL*BYTE_W +: BYTE_W];

   assign standby_o   = gen_r[GC_STANDBY];
   assign in_mute_o   = gen_r[GC_IN_MUTE];
   assign out_mute_o  = gen_r[GC_OUT_MUTE];
   assign treble_hi_o = gen_r[GC_TREBLE_HI];

   assign bass_hi_o    = bass_r[BC_BASS_HI];
   assign alc_speed_o  = bass_r[BC_SPEED_LSB +: 2];
   assign alc_thresh_o = bass_r[BC_THRESH_LSB +: 2];
   assign alc_en_o     = bass_r[BC_ALC_EN];

   assign fine        = vol_r[VR_FINE_LSB +: 3];
   assign coarse      = vol_r[VR_COARSE_LSB +: 3];
   assign vol_atten_o = 6'(coarse) * 6'd8 + 6'(fine);
   assign out_gain_o  = vol_r[VR_GAIN];
   assign out_damp_o  = vol_r[VR_DAMP];
endmodule

// File: rtl/audio_ctl_i2c_chk.sv
module audio_ctl_i2c_chk #(
   parameter int NUM_REGS = 3
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  scl_s,
   input logic                  sda_pull_o,
   input logic                  start_det,
   input logic                  byte_stb,
   input logic                  byte_first,
   input logic [3:0]            wr_idx,
   input logic [NUM_REGS*8-1:0] reg_flat,
   input logic [5:0]            vol_atten_o
);
   // R7
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!sda_pull_o && vol_atten_o == 6'd0 && reg_flat == '0));

   // R2
   pull_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(sda_pull_o) |-> !scl_s);

   // R6
   start_release_chk: assert property (@(posedge clk) disable iff (rst)
      start_det |=> !sda_pull_o);

   // R5
   unused_idx_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (byte_stb && !byte_first && wr_idx >= 4'(NUM_REGS)) |=> $stable(reg_flat));

   // R1
   regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !byte_stb |=> $stable(reg_flat));
endmodule

bind audio_ctl_i2c audio_ctl_i2c_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .scl_s       (scl_s),
   .sda_pull_o  (sda_pull_o),
   .start_det   (start_det),
   .byte_stb    (byte_stb),
   .byte_first  (byte_first),
   .wr_idx      (wr_idx),
   .reg_flat    (reg_flat),
   .vol_atten_o (vol_atten_o)
);

// File: tb/audio_ctl_i2c_tb.sv
module audio_ctl_i2c_tb;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_line;
   logic sda_pull_o, standby_o, in_mute_o, out_mute_o, treble_hi_o;
   logic bass_hi_o, alc_en_o, out_gain_o, out_damp_o;
   logic [1:0] alc_speed_o, alc_thresh_o;
   logic [5:0] vol_atten_o;

   int total = 0;
   int bad = 0;
   logic [7:0] ref_r [3];
   logic [7:0] dbuf [6];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = sda_m & ~sda_pull_o;

   audio_ctl_i2c u_dut (
      .clk (clk), .rst (rst), .scl_i (scl_m), .sda_i (sda_line),
      .sda_pull_o (sda_pull_o), .standby_o (standby_o), .in_mute_o (in_mute_o),
      .out_mute_o (out_mute_o), .treble_hi_o (treble_hi_o), .bass_hi_o (bass_hi_o),
      .alc_en_o (alc_en_o), .alc_speed_o (alc_speed_o), .alc_thresh_o (alc_thresh_o),
      .vol_atten_o (vol_atten_o), .out_gain_o (out_gain_o), .out_damp_o (out_damp_o)
   );

   task automatic chk(input string rq, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      acked = sda_pull_o;
      wq(); scl_m = 1'b0; wq();
   endtask

   function automatic int exp_atten();
      return 8 * int'(ref_r[2][5:3]) + int'(ref_r[2][2:0]);
   endfunction

   task automatic check_all(input string why);
      chk({"R9 standby ", why}, standby_o, ref_r[0][0]);
      chk({"R9 in_mute ", why}, in_mute_o, ref_r[0][1]);
      chk({"R9 out_mute ", why}, out_mute_o, ref_r[0][2]);
      chk({"R9 treble_hi ", why}, treble_hi_o, ref_r[0][3]);
      chk({"R10 bass_hi ", why}, bass_hi_o, ref_r[1][0]);
      chk({"R10 speed ", why}, alc_speed_o, ref_r[1][2:1]);
      chk({"R10 thresh ", why}, alc_thresh_o, ref_r[1][4:3]);
      chk({"R10 alc_en ", why}, alc_en_o, ref_r[1][5]);
      chk({"R8 atten ", why}, vol_atten_o, exp_atten());
      chk({"R8 gain ", why}, out_gain_o, ref_r[2][6]);
      chk({"R8 damp ", why}, out_damp_o, ref_r[2][7]);
   endtask

   // one transfer: address, index byte, n data bytes from dbuf
   task automatic xfer(input logic [7:0] addr, input logic [7:0] sub, input int n,
                       input bit with_stop);
      logic ack;
      bit match;
      int idx;
      bit inc;
      match = (addr == 8'h88);
      bus_start();
      send_byte(addr, ack);
      chk("R1 address acknowledge", ack, match);
      send_byte(sub, ack);
      chk(match ? "R2 index byte ack" : "R1 ignored index byte", ack, match);
      idx = int'(sub[3:0]);
      inc = sub[4];
      for (int k = 0; k < n; k++) begin
         send_byte(dbuf[k], ack);
         chk(match ? "R2 data byte ack" : "R1 ignored data byte", ack, match);
         if (match) begin
            if (idx < 3) ref_r[idx] = dbuf[k];
            if (inc) idx = (idx >= 2) ? 0 : idx + 1;
         end
      end
      if (with_stop) bus_stop();
      wq();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      for (int i = 0; i < 3; i++) ref_r[i] = 8'h00;
      repeat (5) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R7 reset pull", sda_pull_o, 0);
      check_all("R7 reset");

      // R8 full-scale volume
      dbuf[0] = 8'hFF;
      xfer(8'h88, 8'h02, 1, 1'b1);
      check_all("R8 max volume");

      // R3 top index bits ignored
      dbuf[0] = 8'h15;
      xfer(8'h88, 8'hE2, 1, 1'b1);
      chk("R3 masked index atten", vol_atten_o, 21);
      check_all("R3 masked index");

      // R1 wrong addresses
      dbuf[0] = 8'hAA;
      xfer(8'h89, 8'h00, 1, 1'b1);
      xfer(8'h44, 8'h02, 1, 1'b1);
      check_all("R1 wrong address");

      // R4 auto-advance through all registers and wrap
      dbuf[0] = 8'h0F; dbuf[1] = 8'h3F; dbuf[2] = 8'h47; dbuf[3] = 8'h05;
      xfer(8'h88, 8'h10, 4, 1'b1);
      check_all("R4 advance and wrap");

      // R4 no advance: same register twice
      dbuf[0] = 8'h01; dbuf[1] = 8'h0A;
      xfer(8'h88, 8'h01, 2, 1'b1);
      check_all("R4 no advance");

      // R5 unused index discarded; with advance wraps to 0
      dbuf[0] = 8'hFF;
      xfer(8'h88, 8'h03, 1, 1'b1);
      check_all("R5 discard");
      dbuf[0] = 8'hFF; dbuf[1] = 8'h06;
      xfer(8'h88, 8'h13, 2, 1'b1);
      check_all("R5 discard then wrap");

      // R6 repeated start: next byte is an index again
      dbuf[0] = 8'h08;
      xfer(8'h88, 8'h00, 1, 1'b0);
      dbuf[0] = 8'h2B;
      xfer(8'h88, 8'h01, 1, 1'b1);
      check_all("R6 repeated start");

      // random traffic
      for (int t = 0; t < 40; t++) begin
         logic [7:0] addr, sub;
         int n;
         addr = ($urandom_range(0, 9) < 8) ? 8'h88 : 8'($urandom);
         sub = {3'($urandom), 1'($urandom), 4'($urandom_range(0, 4))};
         n = $urandom_range(0, 4);
         for (int k = 0; k < 6; k++) dbuf[k] = 8'($urandom);
         xfer(addr, sub, n, $urandom_range(0, 3) != 0);
         check_all("random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule